// File: doc/BRIEF.md
# Variable-Rate Serial Clock Generator

This block derives the serial clock of a master serial port from the system clock. Each half-period of the serial clock lasts a whole number of system cycles, set by one of two 16-bit divider values. In fixed-rate mode only the first divider is used, so the output runs at a constant frequency. In variable-rate mode a 32-bit pattern word picks the divider for each half-period in turn. One pattern therefore shapes the clock across the 16 periods of a 16-bit word.

The engine that owns the transfer raises `run` while it wants clock edges and lowers it to stop. `enable` gates the whole block. Besides the clock itself, the block gives two one-cycle strobes. One marks the leading edge, where the clock leaves its idle level, and the other marks the trailing edge, where it returns to idle. The shift datapath can time its sampling and shifting from these strobes.

Top module: `vclk_gen`

## Requirements
- R1: While `enable` or `run` is low, and during reset, `sclk` equals `cpol` and neither strobe is asserted. This holds from the cycle after the inputs go low.
- R2: With `var_en` low, every half-period lasts `div_a`+1 system cycles, so the clock period is 2*(`div_a`+1) cycles. `div_b` and `pattern` have no effect.
- R3: With `var_en` high, half-period k of a run (k=0 is the idle-level wait before the first leading edge) uses pattern bit 31-(k mod 32). Bit value 0 gives `div_a`+1 cycles and bit value 1 gives `div_b`+1 cycles.
- R4: After 32 half-periods the pattern index wraps back to bit 31 without a gap.
- R5: When `enable` and `run` are first seen high at a rising clock edge, the first leading edge appears d+2 edges later (counting that edge as 1), where d is the divider chosen for half-period 0.
- R6: `lead_stb` is high for exactly the one cycle in which `sclk` first shows the non-idle level. `trail_stb` is high for the one cycle in which `sclk` first returns to `cpol`. The two strobes are never high together.
- R7: The divider for a half-period is sampled when that half-period begins. A change to `div_a`, `div_b` or `pattern` during a half-period does not alter that half-period's length; it applies from the next one.
- R8: Lowering `run` in the middle of a half-period returns `sclk` to idle in the next cycle with no trailing strobe. The next run starts again from pattern bit 31.
- R9: With `cpol` high the clock idles high and the leading edge is a falling edge. Timing is otherwise identical to `cpol` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable |
| run | input | 1 | Start (high) / stop (low) request from the transfer engine |
| var_en | input | 1 | Selects variable-rate (pattern) mode |
| div_a | input | 16 | First divider; half-period = div_a+1 cycles |
| div_b | input | 16 | Second divider; half-period = div_b+1 cycles |
| pattern | input | 32 | Per-half-period divider selection, consumed from bit 31 down |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse with the leading edge of sclk |
| trail_stb | output | 1 | One-cycle pulse with the trailing edge of sclk |

## Verification
The hardest behaviour to reach from the ports is a divider or pattern change that lands inside a half-period that is already running. The sampling rule is only visible when the change falls strictly between the start of a phase and its end. The bench drives inputs on falling edges and counts falling edges from the start request. This lets it change `div_a` at a known point two cycles into the first phase and then measure both that phase and the following one. The bench uses the same counting to stop the clock right after a leading strobe, and it runs more than 32 half-periods to reach the pattern wrap.

// File: rtl/vclk_pkg.sv
package vclk_pkg;

  // Level of the serial clock relative to its idle value.
  typedef enum logic {
    LVL_IDLE   = 1'b0,
    LVL_ACTIVE = 1'b1
  } vclk_level_e;

  // Number of system cycles spent in one half-period for a given divider.
  function automatic int unsigned half_cycles(input int unsigned div);
    return div + 1;
  endfunction

endpackage

// File: rtl/vclk_step_sel.sv
module vclk_step_sel #(
  parameter int DIV_W  = 16,
  parameter int PAT_W  = 32,
  parameter int STEP_W = $clog2(PAT_W)
) (
  input  logic              running,
  input  logic [STEP_W-1:0] step_q,
  input  logic              var_en,
  input  logic [PAT_W-1:0]  pattern,
  input  logic [DIV_W-1:0]  div_a,
  input  logic [DIV_W-1:0]  div_b,
  output logic [STEP_W-1:0] sel_idx,
  output logic              sel_bit,
  output logic [DIV_W-1:0]  load_val
);

  localparam logic [STEP_W-1:0] FIRST_STEP = STEP_W'(PAT_W - 1);

  // Index of the half-period about to begin: bit PAT_W-1 at start,
  // otherwise the one after the current step (wrapping modulo PAT_W).
  function automatic logic [STEP_W-1:0] upcoming(input logic run_q,
                                                 input logic [STEP_W-1:0] cur);
    return run_q ? STEP_W'(cur - STEP_W'(1)) : FIRST_STEP;
  endfunction

  function automatic logic [DIV_W-1:0] pick_div(input logic use_b,
                                                input logic [DIV_W-1:0] a,
                                                input logic [DIV_W-1:0] b);
    return use_b ? b : a;
  endfunction

  always_comb begin
    sel_idx  = upcoming(running, step_q);
    sel_bit  = var_en & pattern[sel_idx];
    load_val = pick_div(sel_bit, div_a, div_b);
  end

endmodule

// File: rtl/vclk_phase_timer.sv
module vclk_phase_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [DIV_W-1:0] load_val,
  output logic             running,
  output logic             phase_end
);

  logic [DIV_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      remain_q <= '0;
    end else if (!active) begin
      running  <= 1'b0;
      remain_q <= '0;
    end else if (!running) begin
      running  <= 1'b1;
      remain_q <= load_val;
    end else if (remain_q == '0) begin
      remain_q <= load_val;
    end else begin
      remain_q <= remain_q - DIV_W'(1);
    end
  end

  assign phase_end = running & active & (remain_q == '0);

endmodule

// File: rtl/vclk_edge_gen.sv
module vclk_edge_gen #(
  parameter int PAT_W  = 32,
  parameter int STEP_W = $clog2(PAT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              phase_end,
  output logic [STEP_W-1:0] step_q,
  output vclk_pkg::vclk_level_e level_q,
  output logic              lead_q,
  output logic              trail_q
);
  import vclk_pkg::*;

  localparam logic [STEP_W-1:0] FIRST_STEP = STEP_W'(PAT_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= FIRST_STEP;
      level_q <= LVL_IDLE;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!active) begin
      step_q  <= FIRST_STEP;
      level_q <= LVL_IDLE;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= phase_end & (level_q == LVL_IDLE);
      trail_q <= phase_end & (level_q == LVL_ACTIVE);
      if (phase_end) begin
        step_q  <= STEP_W'(step_q - STEP_W'(1));
        level_q <= (level_q == LVL_IDLE) ? LVL_ACTIVE : LVL_IDLE;
      end
    end
  end

endmodule

// File: rtl/vclk_gen.sv
module vclk_gen #(
  parameter int DIV_W = 16,
  parameter int PAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run,
  input  logic             var_en,
  input  logic [DIV_W-1:0] div_a,
  input  logic [DIV_W-1:0] div_b,
  input  logic [PAT_W-1:0] pattern,
  input  logic             cpol,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  import vclk_pkg::*;

  localparam int STEP_W = $clog2(PAT_W);

  // Named internal events, brought out for the checker.
  logic              active;
  logic              running;
  logic              phase_end;
  logic [STEP_W-1:0] step_idx;
  logic [STEP_W-1:0] sel_idx;
  logic              sel_bit;
  logic [DIV_W-1:0]  load_val;
  vclk_level_e       level_q;

  assign active = enable & run;

  vclk_step_sel #(.DIV_W(DIV_W), .PAT_W(PAT_W), .STEP_W(STEP_W)) u_sel (
    .running (running),
    .step_q  (step_idx),
    .var_en  (var_en),
    .pattern (pattern),
    .div_a   (div_a),
    .div_b   (div_b),
    .sel_idx (sel_idx),
    .sel_bit (sel_bit),
    .load_val(load_val)
  );

  vclk_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .load_val (load_val),
    .running  (running),
    .phase_end(phase_end)
  );

  vclk_edge_gen #(.PAT_W(PAT_W), .STEP_W(STEP_W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .phase_end(phase_end),
    .step_q   (step_idx),
    .level_q  (level_q),
    .lead_q   (lead_stb),
    .trail_q  (trail_stb)
  );

  assign sclk = cpol ^ (level_q == LVL_ACTIVE);

endmodule

// File: rtl/vclk_gen_checker.sv
module vclk_gen_checker #(
  parameter int PAT_W  = 32,
  parameter int STEP_W = $clog2(PAT_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              run,
  input logic              cpol,
  input logic              sclk,
  input logic              lead_stb,
  input logic              trail_stb,
  input logic              phase_end,
  input logic [STEP_W-1:0] step_idx
);

  // R1: stopped means idle level and silence on the next cycle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || !run) |=> (!lead_stb && !trail_stb && sclk == cpol));

  // R6: strobes are exclusive
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  // R6: leading strobe coincides with the non-idle level
  a_r6_lead_level: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != cpol));

  // R6: trailing strobe coincides with the idle level
  a_r6_trail_level: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sclk == cpol));

  // R6: every end of a half-period produces a strobe on the next cycle
  a_r6_end_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |=> (lead_stb || trail_stb));

  // R8: a clock change without a strobe can only come from a stop
  a_r8_no_silent_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cpol) && sclk != $past(sclk)) |->
      (lead_stb || trail_stb || !$past(enable && run)));

  // R3: the pattern index steps down by one at each half-period end
  a_r3_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |=> (step_idx == STEP_W'($past(step_idx) - STEP_W'(1))));

endmodule

bind vclk_gen vclk_gen_checker #(.PAT_W(PAT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .run      (run),
  .cpol     (cpol),
  .sclk     (sclk),
  .lead_stb (lead_stb),
  .trail_stb(trail_stb),
  .phase_end(phase_end),
  .step_idx (step_idx)
);

// File: tb/vclk_gen_test.sv
module vclk_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        run = 1'b0;
  logic        var_en = 1'b0;
  logic [15:0] div_a = '0;
  logic [15:0] div_b = '0;
  logic [31:0] pattern = '0;
  logic        cpol = 1'b0;
  logic        sclk;
  logic        lead_stb;
  logic        trail_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vclk_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .var_en(var_en),
    .div_a(div_a), .div_b(div_b), .pattern(pattern), .cpol(cpol),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Wait 'gap' falling edges; the strobe must appear only on the last one.
  task automatic expect_strobe(input int gap, input bit is_lead, input string tag);
    int spurious = 0;
    for (int i = 1; i <= gap; i++) begin
      @(negedge clk);
      if (i < gap && (lead_stb || trail_stb)) spurious++;
    end
    check(spurious == 0 && lead_stb == is_lead && trail_stb == !is_lead &&
          sclk == (cpol ^ is_lead), tag,
          {spurious, 2'(lead_stb), 2'(trail_stb), 2'(sclk)},
          {2'(is_lead), 2'(!is_lead), 2'(cpol ^ is_lead)});
  endtask

  task automatic stop_and_check(input string tag);
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sclk == cpol && !lead_stb && !trail_stb, tag, sclk, cpol);
  endtask

  // Run nhalf half-periods with expected lengths computed from the settings.
  task automatic run_sweep(input int nhalf, input string tag);
    run = 1'b1;
    for (int k = 0; k < nhalf; k++) begin
      int d;
      d = (var_en && pattern[31 - (k % 32)]) ? int'(div_b) : int'(div_a);
      expect_strobe((k == 0) ? d + 2 : d + 1, (k % 2) == 0, tag);
    end
    stop_and_check({tag, " R1 stop"});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state and idle with enable low
    @(negedge clk);
    check(sclk == 1'b0 && !lead_stb && !trail_stb, "R1 reset", sclk, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    div_a = 16'd0;
    repeat (6) begin
      @(negedge clk);
      check(sclk == cpol && !lead_stb && !trail_stb, "R1 enable low", sclk, cpol);
    end
    run = 1'b0;
    enable = 1'b1;

    // R2 R5 R9: fixed mode sweep, both polarities, pattern/div_b ignored
    pattern = 32'hFFFF_FFFF;
    div_b = 16'd7;
    for (int p = 0; p < 2; p++) begin
      for (int dv = 0; dv < 5; dv++) begin
        cpol = p[0];
        div_a = 16'(dv);
        @(negedge clk);
        run_sweep(8, p ? "R2 R9 fixed cpol1" : "R2 R5 fixed cpol0");
      end
    end

    // R3 R4: variable mode, several patterns, beyond one pattern wrap
    var_en = 1'b1;
    for (int t = 0; t < 4; t++) begin
      case (t)
        0: pattern = 32'hAAAA_AAAA;
        1: pattern = 32'hF0F0_0FF0;
        2: pattern = 32'h8000_0001;
        default: pattern = 32'h3C5A_96E1;
      endcase
      div_a = 16'd1;
      div_b = 16'(3 + t);
      cpol = t[0];
      @(negedge clk);
      run_sweep(70, "R3 R4 pattern");
    end

    // R7: divider change inside the first half-period
    var_en = 1'b0;
    cpol = 1'b0;
    div_a = 16'd5;
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!lead_stb && !trail_stb, "R7 quiet", lead_stb, 0);
    div_a = 16'd1;
    expect_strobe(5, 1'b1, "R7 current phase kept");
    expect_strobe(2, 1'b0, "R7 new divider next phase");
    expect_strobe(2, 1'b1, "R7 new divider next phase");

    // R8: stop right after a leading edge, then restart from bit 31
    run = 1'b0;
    @(negedge clk);
    check(sclk == cpol && !lead_stb && !trail_stb, "R8 stop mid-phase", sclk, cpol);
    repeat (4) begin
      @(negedge clk);
      check(sclk == cpol && !lead_stb && !trail_stb, "R8 stays idle", sclk, cpol);
    end
    var_en = 1'b1;
    div_a = 16'd0;
    div_b = 16'd3;
    pattern = 32'h8000_0000;
    run = 1'b1;
    expect_strobe(5, 1'b1, "R8 restart uses bit 31");
    expect_strobe(1, 1'b0, "R8 restart second phase");
    run = 1'b0;
    @(negedge clk);
    check(sclk == cpol && !trail_stb, "R8 no trailing strobe", trail_stb, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule